// File: doc/BRIEF.md
# USB dual-role register file with line-toggle interrupts

This block is the software-visible register file of a USB dual-role (On-The-Go) controller. It keeps the control bits that software sets to request the bus, drop VBUS power or allow a host/peripheral swap. It keeps the PHY control bits. It records interrupt causes in sticky flags and reflects the live session and plug lines in a read-only status word. The role state machine, the analog comparators and the USB data path sit outside. They talk to this block through plain level lines and single-cycle event strobes.

A simple word-aligned register bus reaches the five registers. A write takes effect at the clock edge on which the write enable is high. Read data is combinational from the address, so the bus has no wait states and no back-pressure. The five monitored status lines pass through a synchronizer, and each of them raises its own flag when it toggles. Some role events clear the request bits with no help from software. The flags, masked by the enable register, are merged into one registered interrupt.

Top module: `otg_role_regs`

## Requirements
- R1: Word offsets are fixed: 0x00 control, 0x04 PHY control, 0x08 interrupt enable, 0x0C interrupt status, 0x10 status. Control holds bits 0 (VBUS drop), 1 (bus request), 2 (role-swap enable), 4 (dual-role enable) and 5 (ID wake enable). PHY control holds bits 0, 1, 4 and 5. The enable register holds bits 0..11 and 13. Every other bit, and any other offset, reads as 0.
- R2: The status word is read-only and shows the synchronized lines as bit 0 over-current, 1 ID (1 = B plug), 2 session end, 3 B-session valid, 4 A-session valid, 5 VBUS valid, 6 acting as peripheral, 7 acting as host. Writes to it change nothing.
- R3: While VBUS drop is 1, bus request reads 0, even when the same write sets both bits.
- R4: Bus request clears on a toggle of the synchronized ID line, on the wait-for-VBUS-fall strobe and on the SRP-fail strobe. A clear beats a software write of 1 made in the same cycle.
- R5: Role-swap enable clears on the suspend-to-peripheral strobe, the peripheral-to-wait-connect strobe and the go-idle strobe.
- R6: Interrupt status bits 5, 8, 9, 10 and 11 set on any rising or falling change of the synchronized ID, B-valid, A-valid, VBUS-valid and session-end lines, in that order.
- R7: The event strobes set interrupt status bits 0 (role change), 1 (VBUS error), 2 (SRP fail), 3 (role-swap fail), 4 (go idle), 6 (became peripheral), 7 (became host) and 13 (SRP detected). Bit 12 always reads 0.
- R8: Flags are sticky. Writing 1 to a flag clears it, and writing 0 leaves it unchanged.
- R9: When a hardware set and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R10: The interrupt output is registered. One cycle after any flag and its enable bit are both 1, it is 1. It is 0 when no enabled flag is set.
- R11: A toggle flag cannot set during the SYNC_STAGES+1 clock edges after reset. Lines held steady from reset therefore leave every flag at 0.
- R12: After reset every register reads 0 and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Byte address; bits 1:0 must be 0 for a hit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| ln_overcur | input | 1 | Over-current line |
| ln_id | input | 1 | Plug ID line, 1 = B plug |
| ln_sess_end | input | 1 | Session-end comparator |
| ln_b_valid | input | 1 | B-session valid comparator |
| ln_a_valid | input | 1 | A-session valid comparator |
| ln_vbus_valid | input | 1 | VBUS valid comparator |
| ln_as_periph | input | 1 | Role machine reports peripheral |
| ln_as_host | input | 1 | Role machine reports host |
| ev_role_chg | input | 1 | Strobe: role changed |
| ev_vbus_err | input | 1 | Strobe: VBUS error |
| ev_srp_fail | input | 1 | Strobe: SRP failed |
| ev_swap_fail | input | 1 | Strobe: role swap failed |
| ev_go_idle | input | 1 | Strobe: entered an idle state |
| ev_periph | input | 1 | Strobe: became peripheral |
| ev_host | input | 1 | Strobe: became host |
| ev_srp_det | input | 1 | Strobe: SRP detected |
| ev_a_wait_vfall | input | 1 | Strobe: A side entered wait-for-VBUS-fall |
| ev_a_susp_to_periph | input | 1 | Strobe: A side moved from suspend to peripheral |
| ev_b_periph_to_wcon | input | 1 | Strobe: B side moved from peripheral to wait-connect |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions take the event strobes as single-cycle pulses that the role machine raises on the clock. They also take the bus as writing whole words on aligned addresses. The stimulus drives every strobe and bus write for exactly one cycle, between falling edges. It changes the status lines only on falling edges and leaves each change in place for several cycles, far longer than the synchronizer needs. The set-wins and clear-wins cases are produced on purpose, by raising a strobe in the same cycle as the conflicting write.

// File: rtl/otg_role_pkg.sv
package otg_role_pkg;
  localparam int REG_W  = 32;
  localparam int FLAG_W = 14;
  localparam int NLINES = 8;

  // word index of each register (byte offset / 4)
  localparam logic [2:0] W_CTL  = 3'd0;
  localparam logic [2:0] W_PHY  = 3'd1;
  localparam logic [2:0] W_IEN  = 3'd2;
  localparam logic [2:0] W_ISTS = 3'd3;
  localparam logic [2:0] W_STAT = 3'd4;

  // control bits
  localparam int C_DROP  = 0;
  localparam int C_BREQ  = 1;
  localparam int C_SWAP  = 2;
  localparam int C_OTGEN = 4;
  localparam int C_WAKE  = 5;

  localparam logic [REG_W-1:0]  PHY_MASK  = 32'h0000_0033;
  localparam logic [FLAG_W-1:0] FLAG_MASK = 14'h2FFF;

  // status line positions
  localparam int L_OVC = 0;
  localparam int L_ID  = 1;
  localparam int L_SE  = 2;
  localparam int L_BV  = 3;
  localparam int L_AV  = 4;
  localparam int L_VB  = 5;

  // flag positions
  localparam int F_ROLE = 0;
  localparam int F_VBE  = 1;
  localparam int F_SRPF = 2;
  localparam int F_SWPF = 3;
  localparam int F_IDLE = 4;
  localparam int F_ID   = 5;
  localparam int F_PER  = 6;
  localparam int F_HST  = 7;
  localparam int F_BV   = 8;
  localparam int F_AV   = 9;
  localparam int F_VB   = 10;
  localparam int F_SE   = 11;
  localparam int F_SRPD = 13;
endpackage

// File: rtl/otg_line_sync.sv
module otg_line_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] toggle
);
  localparam int FILL  = STAGES + 1;
  localparam int CNT_W = $clog2(FILL + 1);

  logic [STAGES-1:0][WIDTH-1:0] chain;
  logic [WIDTH-1:0]             prev_q;
  logic [CNT_W-1:0]             arm_cnt;
  logic                         armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain   <= '0;
      prev_q  <= '0;
      arm_cnt <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev_q <= chain[STAGES-1];
      if (!armed) arm_cnt <= arm_cnt + 1'b1;
    end
  end

  // edges are masked until the pipeline has filled with real line values
  assign armed  = (arm_cnt == CNT_W'(FILL));
  assign dout   = chain[STAGES-1];
  assign toggle = armed ? (chain[STAGES-1] ^ prev_q) : '0;
endmodule

// File: rtl/otg_w1c_bank.sv
module otg_w1c_bank #(
  parameter int               WIDTH = 14,
  parameter logic [WIDTH-1:0] MASK  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  input  logic [WIDTH-1:0] en_i,
  output logic [WIDTH-1:0] flags_o,
  output logic             irq_o
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      if (MASK[i]) begin : g_live
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)        bit_q <= 1'b0;
          else if (set_i[i]) bit_q <= 1'b1;   // hardware set beats clear
          else if (clr_i[i]) bit_q <= 1'b0;
        end
        assign flags_o[i] = bit_q;
      end else begin : g_rsvd
        assign flags_o[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(flags_o & en_i);
  end
endmodule

// File: rtl/otg_ctl_bits.sv
module otg_ctl_bits
  import otg_role_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [5:0]       wdata,
  input  logic             id_toggle,
  input  logic             ev_a_wait_vfall,
  input  logic             ev_srp_fail,
  input  logic             ev_a_susp_to_periph,
  input  logic             ev_b_periph_to_wcon,
  input  logic             ev_go_idle,
  output logic [REG_W-1:0] ctl_o
);
  logic drop_q, breq_q, swap_q, otgen_q, wake_q;
  logic drop_n, breq_n, swap_n;
  logic breq_kill, swap_kill;

  assign breq_kill = id_toggle | ev_a_wait_vfall | ev_srp_fail;
  assign swap_kill = ev_a_susp_to_periph | ev_b_periph_to_wcon | ev_go_idle;

  always_comb begin
    drop_n = wr_en ? wdata[C_DROP] : drop_q;
    breq_n = wr_en ? wdata[C_BREQ] : breq_q;
    swap_n = wr_en ? wdata[C_SWAP] : swap_q;
    if (drop_n || breq_kill) breq_n = 1'b0;
    if (swap_kill)           swap_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q <= 1'b0; breq_q <= 1'b0; swap_q <= 1'b0;
      otgen_q <= 1'b0; wake_q <= 1'b0;
    end else begin
      drop_q <= drop_n;
      breq_q <= breq_n;
      swap_q <= swap_n;
      if (wr_en) begin
        otgen_q <= wdata[C_OTGEN];
        wake_q  <= wdata[C_WAKE];
      end
    end
  end

  always_comb begin
    ctl_o          = '0;
    ctl_o[C_DROP]  = drop_q;
    ctl_o[C_BREQ]  = breq_q;
    ctl_o[C_SWAP]  = swap_q;
    ctl_o[C_OTGEN] = otgen_q;
    ctl_o[C_WAKE]  = wake_q;
  end

  logic unused_w3;
  assign unused_w3 = wdata[3];
endmodule

// File: rtl/otg_role_regs.sv
module otg_role_regs
  import otg_role_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              ln_overcur,
  input  logic              ln_id,
  input  logic              ln_sess_end,
  input  logic              ln_b_valid,
  input  logic              ln_a_valid,
  input  logic              ln_vbus_valid,
  input  logic              ln_as_periph,
  input  logic              ln_as_host,
  input  logic              ev_role_chg,
  input  logic              ev_vbus_err,
  input  logic              ev_srp_fail,
  input  logic              ev_swap_fail,
  input  logic              ev_go_idle,
  input  logic              ev_periph,
  input  logic              ev_host,
  input  logic              ev_srp_det,
  input  logic              ev_a_wait_vfall,
  input  logic              ev_a_susp_to_periph,
  input  logic              ev_b_periph_to_wcon,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  word;
  logic              aligned;
  logic              wr_ctl, wr_phy, wr_ien, wr_ists;
  logic [REG_W-1:0]  ctl_q, phy_q;
  logic [FLAG_W-1:0] ien_q, flag_q, flag_set, flag_clr;
  logic [NLINES-1:0] lines_raw, lines_s, line_tgl;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_ctl  = bus_wr_en && aligned && (word == IDX_W'(W_CTL));
  assign wr_phy  = bus_wr_en && aligned && (word == IDX_W'(W_PHY));
  assign wr_ien  = bus_wr_en && aligned && (word == IDX_W'(W_IEN));
  assign wr_ists = bus_wr_en && aligned && (word == IDX_W'(W_ISTS));

  assign lines_raw = {ln_as_host, ln_as_periph, ln_vbus_valid, ln_a_valid,
                      ln_b_valid, ln_sess_end, ln_id, ln_overcur};

  otg_line_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(lines_raw), .dout(lines_s), .toggle(line_tgl)
  );

  otg_ctl_bits u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctl), .wdata(bus_wdata[5:0]),
    .id_toggle(line_tgl[L_ID]), .ev_a_wait_vfall(ev_a_wait_vfall),
    .ev_srp_fail(ev_srp_fail), .ev_a_susp_to_periph(ev_a_susp_to_periph),
    .ev_b_periph_to_wcon(ev_b_periph_to_wcon), .ev_go_idle(ev_go_idle),
    .ctl_o(ctl_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_q <= '0;
      ien_q <= '0;
    end else begin
      if (wr_phy) phy_q <= bus_wdata & PHY_MASK;
      if (wr_ien) ien_q <= bus_wdata[FLAG_W-1:0] & FLAG_MASK;
    end
  end

  always_comb begin
    flag_set         = '0;
    flag_set[F_ROLE] = ev_role_chg;
    flag_set[F_VBE]  = ev_vbus_err;
    flag_set[F_SRPF] = ev_srp_fail;
    flag_set[F_SWPF] = ev_swap_fail;
    flag_set[F_IDLE] = ev_go_idle;
    flag_set[F_PER]  = ev_periph;
    flag_set[F_HST]  = ev_host;
    flag_set[F_SRPD] = ev_srp_det;
    flag_set[F_ID]   = line_tgl[L_ID];
    flag_set[F_BV]   = line_tgl[L_BV];
    flag_set[F_AV]   = line_tgl[L_AV];
    flag_set[F_VB]   = line_tgl[L_VB];
    flag_set[F_SE]   = line_tgl[L_SE];
  end

  assign flag_clr = wr_ists ? (bus_wdata[FLAG_W-1:0] & FLAG_MASK) : '0;

  otg_w1c_bank #(.WIDTH(FLAG_W), .MASK(FLAG_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr),
    .en_i(ien_q), .flags_o(flag_q), .irq_o(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (word)
        IDX_W'(W_CTL):  bus_rdata = ctl_q;
        IDX_W'(W_PHY):  bus_rdata = phy_q;
        IDX_W'(W_IEN):  bus_rdata = REG_W'(ien_q);
        IDX_W'(W_ISTS): bus_rdata = REG_W'(flag_q);
        IDX_W'(W_STAT): bus_rdata = REG_W'(lines_s);
        default:        bus_rdata = '0;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[REG_W-1:FLAG_W], line_tgl[7:6], line_tgl[L_OVC]};
endmodule

// File: rtl/otg_role_regs_chk.sv
module otg_role_regs_chk
  import otg_role_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [FLAG_W-1:0] set_vec,
  input logic [FLAG_W-1:0] clr_vec,
  input logic [FLAG_W-1:0] flags,
  input logic [FLAG_W-1:0] ien,
  input logic              irq,
  input logic [REG_W-1:0]  ctl,
  input logic              ev_srp_fail,
  input logic              ev_a_wait_vfall,
  input logic              ev_a_susp_to_periph,
  input logic              ev_b_periph_to_wcon,
  input logic              ev_go_idle
);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((flags & $past(clr_vec) & ~$past(set_vec)) == '0));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> (($past(flags) & ~flags) == '0));

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ien) != '0) |=> irq);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ien) == '0) |=> !irq);

  // R4
  breq_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_srp_fail || ev_a_wait_vfall) |=> !ctl[C_BREQ]);

  // R5
  swap_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_a_susp_to_periph || ev_b_periph_to_wcon || ev_go_idle) |=> !ctl[C_SWAP]);

  // R3
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[C_DROP] |-> !ctl[C_BREQ]);
endmodule

bind otg_role_regs otg_role_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .set_vec(flag_set), .clr_vec(flag_clr),
  .flags(flag_q), .ien(ien_q), .irq(irq), .ctl(ctl_q),
  .ev_srp_fail(ev_srp_fail), .ev_a_wait_vfall(ev_a_wait_vfall),
  .ev_a_susp_to_periph(ev_a_susp_to_periph),
  .ev_b_periph_to_wcon(ev_b_periph_to_wcon), .ev_go_idle(ev_go_idle)
);

// File: tb/tb_otg_role_regs.sv
`timescale 1ns/1ps
module tb_otg_role_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  ln = '0;   // {host,periph,vbusv,av,bv,send,id,ovc}
  logic [10:0] ev = '0;   // {b_p2w,a_s2p,a_wvf,srpd,host,per,idle,swpf,srpf,vbe,role}
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  otg_role_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ln_overcur(ln[0]), .ln_id(ln[1]), .ln_sess_end(ln[2]), .ln_b_valid(ln[3]),
    .ln_a_valid(ln[4]), .ln_vbus_valid(ln[5]), .ln_as_periph(ln[6]), .ln_as_host(ln[7]),
    .ev_role_chg(ev[0]), .ev_vbus_err(ev[1]), .ev_srp_fail(ev[2]), .ev_swap_fail(ev[3]),
    .ev_go_idle(ev[4]), .ev_periph(ev[5]), .ev_host(ev[6]), .ev_srp_det(ev[7]),
    .ev_a_wait_vfall(ev[8]), .ev_a_susp_to_periph(ev[9]), .ev_b_periph_to_wcon(ev[10]),
    .irq(irq)
  );

  // {addr, write data, expected read-back}
  localparam int NV = 10;
  localparam logic [68:0] VEC [NV] = '{
    {5'h00, 32'h0000_003F, 32'h0000_0035},
    {5'h00, 32'h0000_0016, 32'h0000_0016},
    {5'h04, 32'hFFFF_FFFF, 32'h0000_0033},
    {5'h04, 32'h0000_0012, 32'h0000_0012},
    {5'h08, 32'hFFFF_FFFF, 32'h0000_2FFF},
    {5'h08, 32'h0000_0000, 32'h0000_0000},
    {5'h10, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'h14, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'h0C, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'h00, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr_en = 1'b0;
  endtask

  task automatic rdr(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(input logic [10:0] v);
    @(negedge clk); ev = v;
    @(negedge clk); ev = '0;
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    waitc(3);
    @(negedge clk); rst_n = 1'b1;
    waitc(6);
    // R12 reset state
    for (int a = 0; a < 5; a++) begin
      rdr(5'(a * 4), rd); check("R12 reset read", rd, 32'h0);
    end
    check("R12 reset irq", {31'b0, irq}, 32'h0);

    // R1 R2 R3 table
    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][68:64], VEC[k][63:32]);
      rdr(VEC[k][68:64], rd);
      check($sformatf("R1/R2/R3 vector %0d", k), rd, VEC[k][31:0]);
    end

    // R6 toggle flag with enable off, R10 gating, R2 status
    @(negedge clk); ln[3] = 1'b1;
    waitc(6);
    rdr(5'h0C, rd); check("R6 b-valid rise", rd, 32'h100);
    rdr(5'h10, rd); check("R2 status lines", rd, 32'h08);
    check("R10 masked irq", {31'b0, irq}, 32'h0);
    wr(5'h08, 32'h100); waitc(3);
    check("R10 enabled irq", {31'b0, irq}, 32'h1);
    wr(5'h0C, 32'h0); rdr(5'h0C, rd); check("R8 write zero", rd, 32'h100);
    wr(5'h0C, 32'h100); rdr(5'h0C, rd); check("R8 write one", rd, 32'h0);
    waitc(3); check("R10 irq drops", {31'b0, irq}, 32'h0);
    wr(5'h08, 32'h0);

    // R6 falling edge and several lines at once
    @(negedge clk); ln[3] = 1'b0; ln[2] = 1'b1; ln[4] = 1'b1; ln[5] = 1'b1;
    waitc(6);
    rdr(5'h0C, rd); check("R6 multi toggle", rd, 32'hF00);
    wr(5'h0C, 32'hFFFF_FFFF);

    // R7 event strobes
    pulse(11'h0FF);
    rdr(5'h0C, rd); check("R7 event flags", rd, 32'h20DF);
    wr(5'h0C, 32'hFFFF_FFFF);

    // R9 set and clear in the same cycle
    @(negedge clk); ev[7] = 1'b1; bus_wr_en = 1'b1; bus_addr = 5'h0C; bus_wdata = 32'h2000;
    @(negedge clk); ev = '0; bus_wr_en = 1'b0;
    rdr(5'h0C, rd); check("R9 set wins", rd, 32'h2000);
    wr(5'h0C, 32'hFFFF_FFFF);

    // R4 bus request auto-clear
    wr(5'h00, 32'h2);
    @(negedge clk); ln[1] = 1'b1;
    waitc(6);
    rdr(5'h00, rd); check("R4 id toggle clears", rd, 32'h0);
    rdr(5'h0C, rd); check("R6 id flag", rd, 32'h20);
    wr(5'h00, 32'h2); pulse(11'h004);
    rdr(5'h00, rd); check("R4 srp fail clears", rd, 32'h0);
    wr(5'h00, 32'h2); pulse(11'h100);
    rdr(5'h00, rd); check("R4 wait-vfall clears", rd, 32'h0);
    @(negedge clk); ev[8] = 1'b1; bus_wr_en = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h2;
    @(negedge clk); ev = '0; bus_wr_en = 1'b0;
    rdr(5'h00, rd); check("R4 clear beats write", rd, 32'h0);

    // R5 swap enable auto-clear
    wr(5'h00, 32'h4); pulse(11'h010);
    rdr(5'h00, rd); check("R5 go idle", rd, 32'h0);
    wr(5'h00, 32'h4); pulse(11'h200);
    rdr(5'h00, rd); check("R5 suspend to periph", rd, 32'h0);
    wr(5'h00, 32'h14); pulse(11'h400);
    rdr(5'h00, rd); check("R5 periph to wait-connect", rd, 32'h10);

    // R3 drop while bus request set
    wr(5'h00, 32'h2); wr(5'h00, 32'h3);
    rdr(5'h00, rd); check("R3 drop clears request", rd, 32'h1);

    // R11 reset with lines already high
    @(negedge clk); rst_n = 1'b0; ln = 8'hFF;
    waitc(2);
    @(negedge clk); rst_n = 1'b1;
    waitc(8);
    rdr(5'h0C, rd); check("R11 no flag at start", rd, 32'h0);
    rdr(5'h10, rd); check("R2 status all high", rd, 32'hFF);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule